// File: doc/BRIEF.md
# Configurable UART with Handshaking

This block is a full-duplex asynchronous serial transceiver that sits on a microcontroller's peripheral bus. Software writes characters into a transmit holding register. Each character moves into a transmit shift register and is sent on `txd` as a start bit, the data bits least-significant first, an optional parity bit and one or two stop bits. Incoming frames on `rxd` are oversampled at 16 times the bit rate. Each completed character is placed in a receive holding register, and parity, framing and overrun conditions are recorded as sticky flags.

A single programmable divisor sets the bit rate for both directions. The fastest setting gives one bit every 32 core clocks. Software must write a new divisor whenever the core clock frequency changes. Optional flow-control gating can be enabled for each pin: an input that permits transmission, an input that permits reception, an output that signals pending transmit data, and an output that signals free receive space. The block also drives one maskable interrupt and two DMA request lines, which an external engine consumes.

Register map, selected by `addr`:
- 0: writing loads the transmit holding register; reading returns the received character.
- 1: status.
- 2: control.
- 3: divisor.

Top module: `uart_hs`

## Requirements
- R1: After reset the registers and outputs hold these values:
  - status reads 0x0006, control reads 0 and the divisor reads 2;
  - `txd`, `rts_n` and `rtr_n` are 1;
  - `irq`, `drq_tx` and `drq_rx` are 0.
- R2: A transmitted frame has this form:
  - a 0 start bit, then the data bits least-significant first;
  - control[1:0] sets the data length: 0 gives 8 bits, 1 gives 7 bits, 2 or 3 gives 9 bits;
  - when control[2] is 1, a parity bit follows the data: even parity when control[3] is 0, odd parity when it is 1;
  - the frame ends with one stop bit of value 1, or two when control[4] is 1;
  - each bit lasts 16 x D core clocks, where D is the divisor, and D values of 0 or 1 act as 2.
- R3: A received character appears, with its upper bits zero, in data reads. Status bit 0 (receive full) is set when the character arrives and clears only when data is read.
- R4: When parity is enabled and the received parity bit is wrong, status bit 3 is set and the character is still stored.
- R5: When the first stop bit is received as 0, status bit 4 is set.
- R6: When a character completes while receive full is set, the new character is discarded, the stored character is kept, and status bit 5 is set.
- R7: Status bits 3 to 5 stay set until status is read, and a status read clears them.
- R8: A low pulse on `rxd` shorter than half a bit time is not taken as a start bit.
- R9: The transmit path is double buffered:
  - status bit 1 (holding empty) is 1 when the holding register is free, and it returns to 1 once a character moves into the shift register;
  - a second character can be written while the first is being sent, and the two go out back to back;
  - status bit 2 is 1 only when both the holding register and the shift register are empty.
- R10: With control[5] set, no new frame starts while `cts_n` is 1. The waiting character starts once `cts_n` goes to 0.
- R11: With control[6] set, start bits are ignored while `enrx_n` is 1.
- R12: Two outputs signal flow state:
  - with control[7] set, `rts_n` is 0 while a character is waiting or being sent;
  - with control[8] set, `rtr_n` is 0 while receive full is clear;
  - each output is 1 while its enable bit is clear.
- R13: `irq` is the OR of three enabled conditions:
  - receive full, enabled by control[9];
  - holding empty, enabled by control[10];
  - any error flag, enabled by control[11].
- R14: `drq_tx` equals holding empty when control[12] is set. `drq_rx` equals receive full when control[13] is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; triggers read side effects |
| addr | input | 2 | Register select |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Transmit permit, active low |
| enrx_n | input | 1 | Receive permit, active low |
| rts_n | output | 1 | Transmit data pending, active low |
| rtr_n | output | 1 | Receive space available, active low |
| irq | output | 1 | Maskable interrupt |
| drq_tx | output | 1 | DMA request for transmit |
| drq_rx | output | 1 | DMA request for receive |

## Verification
The assertions take three things for granted about the inputs:
- the control register is not rewritten while a frame is in flight;
- read strobes last exactly one cycle;
- `cts_n` changes only between clock edges.

The stimulus keeps within these assumptions in three ways:
- every register access is a single-cycle strobe driven on the falling clock edge;
- control is changed only after the line has been idle for at least two bit times;
- the flow-control inputs are moved only while the bench is idle between frames.

Serial input is either looped back from `txd` or driven a whole bit time at a time, except for the deliberately short glitch.

// File: rtl/uart_hs.sv
module uart_hs #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          txd,
  input  logic          rxd,
  input  logic          cts_n,
  input  logic          enrx_n,
  output logic          rts_n,
  output logic          rtr_n,
  output logic          irq,
  output logic          drq_tx,
  output logic          drq_rx
);
  localparam int FW = 13;

  logic [13:0]   ctrl;
  logic [DW-1:0] div, dcnt;
  wire  [DW-1:0] dlim = (div < DW'(2)) ? DW'(2) : div;
  wire           tick = dcnt >= dlim - DW'(1);

  wire pen = ctrl[2], podd = ctrl[3], stop2 = ctrl[4];
  wire cts_en = ctrl[5], enrx_en = ctrl[6], rts_en = ctrl[7], rtr_en = ctrl[8];
  wire [3:0] nb    = (ctrl[1:0] == 2'd1) ? 4'd7 : (ctrl[1] ? 4'd9 : 4'd8);
  wire [8:0] dmask = (nb == 4'd7) ? 9'h07f : (nb == 4'd8) ? 9'h0ff : 9'h1ff;

  wire wr_data = wr_en && addr == 2'd0;
  wire rd_data = rd_en && addr == 2'd0;
  wire rd_stat = rd_en && addr == 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      div  <= DW'(2);
      dcnt <= '0;
    end else begin
      dcnt <= tick ? '0 : dcnt + DW'(1);
      if (wr_en && addr == 2'd2) ctrl <= wdata[13:0];
      if (wr_en && addr == 2'd3) div  <= wdata;
    end
  end

  // transmit: holding register feeding a frame shift register
  logic [8:0]    thold;
  logic          thold_full, tbusy;
  logic [FW-1:0] tsh, tframe;
  logic [3:0]    tph, tbit, tlen_r;
  wire  [8:0]    td   = thold & dmask;
  wire  [3:0]    tlen = 4'd2 + nb + {3'b0, pen} + {3'b0, stop2};
  wire           tx_go = !tbusy && thold_full && (!cts_en || !cts_n);

  always_comb begin
    tframe    = '1;
    tframe[0] = 1'b0;
    for (int i = 0; i < 9; i++)
      if (i < int'(nb)) tframe[i+1] = td[i];
    if (pen) tframe[nb + 4'd1] = podd ^ (^td);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thold <= '0; thold_full <= 1'b0; tbusy <= 1'b0;
      tsh <= '1; tph <= '0; tbit <= '0; tlen_r <= '0;
    end else begin
      if (tx_go) begin
        tbusy <= 1'b1; tsh <= tframe; tlen_r <= tlen;
        tph <= '0; tbit <= '0; thold_full <= 1'b0;
      end else if (tbusy && tick) begin
        if (tph == 4'd15) begin
          tph <= '0;
          tsh <= {1'b1, tsh[FW-1:1]};
          if (tbit == tlen_r - 4'd1) tbusy <= 1'b0;
          else tbit <= tbit + 4'd1;
        end else tph <= tph + 4'd1;
      end
      if (wr_data) begin
        thold <= wdata[8:0];
        thold_full <= 1'b1;
      end
    end
  end

  assign txd = tbusy ? tsh[0] : 1'b1;

  // receive: 16x oversampling, sample at mid-bit
  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA} rst_e;
  rst_e        rstate;
  logic [1:0]  rsync;
  logic [3:0]  rph, rbit;
  logic [10:0] rsh, rword;
  logic [8:0]  rhold;
  logic        rx_full, pe, fe, ovr;
  wire         rs    = rsync[1];
  wire         rx_on = !enrx_en || !enrx_n;
  wire  [3:0]  rlast = nb + {3'b0, pen};
  wire         rdone = rstate == R_DATA && tick && rph == 4'd15 && rbit == rlast;

  always_comb begin
    rword = rsh;
    rword[rbit] = rs;
  end
  wire [8:0] rdat = rword[8:0] & dmask;
  wire       perr = pen && ((^rdat) ^ rword[nb] ^ podd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsync <= 2'b11; rstate <= R_IDLE; rph <= '0; rbit <= '0;
      rsh <= '0; rhold <= '0; rx_full <= 1'b0;
      pe <= 1'b0; fe <= 1'b0; ovr <= 1'b0;
    end else begin
      rsync <= {rsync[0], rxd};
      if (rd_data) rx_full <= 1'b0;
      if (rd_stat) begin pe <= 1'b0; fe <= 1'b0; ovr <= 1'b0; end
      if (tick) begin
        case (rstate)
          R_IDLE: if (rx_on && !rs) begin rstate <= R_START; rph <= '0; end
          R_START:
            if (rph == 4'd7) begin
              rph <= '0; rbit <= '0;
              rstate <= rs ? R_IDLE : R_DATA;
            end else rph <= rph + 4'd1;
          R_DATA:
            if (rph == 4'd15) begin
              rph <= '0;
              rsh[rbit] <= rs;
              if (rbit == rlast) rstate <= R_IDLE;
              else rbit <= rbit + 4'd1;
            end else rph <= rph + 4'd1;
          default: rstate <= R_IDLE;
        endcase
      end
      if (rdone) begin
        if (rx_full) ovr <= 1'b1;
        else begin
          rhold <= rdat; rx_full <= 1'b1;
          if (perr) pe <= 1'b1;
          if (!rs) fe <= 1'b1;
        end
      end
    end
  end

  wire [5:0] status = {ovr, fe, pe, !thold_full && !tbusy, !thold_full, rx_full};

  always_comb begin
    case (addr)
      2'd0:    rdata = DW'(rhold);
      2'd1:    rdata = DW'(status);
      2'd2:    rdata = DW'(ctrl);
      default: rdata = div;
    endcase
  end

  assign rts_n  = !(rts_en && (thold_full || tbusy));
  assign rtr_n  = !(rtr_en && !rx_full);
  assign irq    = (ctrl[9] && rx_full) || (ctrl[10] && !thold_full) || (ctrl[11] && (pe || fe || ovr));
  assign drq_tx = ctrl[12] && !thold_full;
  assign drq_rx = ctrl[13] && rx_full;
endmodule

module uart_hs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       irq,
  input logic       cts_n,
  input logic       cts_en,
  input logic       tx_busy,
  input logic       hold_full,
  input logic       rx_full,
  input logic       rd_en,
  input logic [1:0] addr,
  input logic       ovr,
  input logic [8:0] rx_hold
);
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> (txd && !irq));

  a_r3_full_until_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !(rd_en && addr == 2'd0)) |=> rx_full);

  a_r6_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> ($stable(rx_hold) && rx_full));

  a_r9_hold_to_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !tx_busy && (!cts_en || !cts_n)) |=> tx_busy);

  a_r10_cts_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && cts_en && cts_n) |=> !tx_busy);
endmodule

bind uart_hs uart_hs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .irq(irq), .cts_n(cts_n),
  .cts_en(ctrl[5]), .tx_busy(tbusy), .hold_full(thold_full),
  .rx_full(rx_full), .rd_en(rd_en), .addr(addr), .ovr(ovr), .rx_hold(rhold)
);

// File: tb/sim_uart_hs.sv
module sim_uart_hs;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        txd, rxd, rx_drv = 1'b1, loop = 1'b1;
  logic        cts_n = 1'b0, enrx_n = 1'b0;
  logic        rts_n, rtr_n, irq, drq_tx, drq_rx;
  int          errs = 0, checks = 0;

  always #2 clk = ~clk;
  assign rxd = loop ? txd : rx_drv;

  uart_hs #(.DW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd), .cts_n(cts_n),
    .enrx_n(enrx_n), .rts_n(rts_n), .rtr_n(rtr_n), .irq(irq),
    .drq_tx(drq_tx), .drq_rx(drq_rx)
  );

  // {divisor, control, data}
  localparam logic [47:0] VEC [8] = '{
    48'h0002_0000_00A5, 48'h0002_0001_01FF, 48'h0003_0002_0155, 48'h0002_0004_00B3,
    48'h0002_000C_00B3, 48'h0002_0014_0001, 48'h0001_000E_01C3, 48'h0000_0011_0040
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  function automatic int nbits(input logic [15:0] c);
    return (c[1:0] == 2'd1) ? 7 : (c[1] ? 9 : 8);
  endfunction

  function automatic int btime(input logic [15:0] dv);
    return 16 * ((dv < 2) ? 2 : int'(dv));
  endfunction

  task automatic expect_frame(input logic [15:0] c, input logic [15:0] d,
                              output logic [12:0] f, output int n);
    int nb = nbits(c);
    logic [8:0] m = d[8:0] & 9'((1 << nb) - 1);
    f = '1; f[0] = 1'b0;
    for (int i = 0; i < nb; i++) f[i+1] = m[i];
    n = 1 + nb;
    if (c[2]) begin f[n] = (^m) ^ c[3]; n++; end
    n += 1 + int'(c[4]);
  endtask

  task automatic check_tx(input logic [15:0] c, input logic [15:0] d,
                          input logic [15:0] dv, input string req);
    logic [12:0] f, got;
    int n, bt;
    bt = btime(dv);
    expect_frame(c, d, f, n);
    got = '1;
    @(negedge txd);
    repeat (bt / 2) @(posedge clk);
    #1 got[0] = txd;
    for (int k = 1; k < n; k++) begin
      repeat (bt) @(posedge clk);
      #1 got[k] = txd;
    end
    chk(req, 32'(got), 32'(f));
  endtask

  task automatic send_char(input logic [8:0] d, input int nb, input bit haspar,
                           input bit par, input bit stopv);
    int bt = btime(16'd2);
    rx_drv = 1'b0; repeat (bt) @(negedge clk);
    for (int i = 0; i < nb; i++) begin rx_drv = d[i]; repeat (bt) @(negedge clk); end
    if (haspar) begin rx_drv = par; repeat (bt) @(negedge clk); end
    rx_drv = stopv; repeat (bt) @(negedge clk);
    rx_drv = 1'b1; repeat (2 * bt) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 outputs", {txd, rts_n, rtr_n, irq, drq_tx, drq_rx}, 6'b111000);
    rd(2'd1, r); chk("R1 status", r, 16'h0006);
    rd(2'd2, r); chk("R1 control", r, 16'h0000);
    rd(2'd3, r); chk("R1 divisor", r, 16'h0002);

    // R2/R3 table of frame formats in loopback
    foreach (VEC[v]) begin
      logic [15:0] dv, c, d;
      {dv, c, d} = VEC[v];
      wr(2'd3, dv); wr(2'd2, c); loop = 1'b1;
      wr(2'd0, d);
      check_tx(c, d, dv, "R2 frame");
      repeat (2 * btime(dv)) @(negedge clk);
      rd(2'd0, r); chk("R3 data", r, d & 16'((1 << nbits(c)) - 1));
      rd(2'd1, r); chk("R3 R4 R5 status clean", r, 16'h0006);
    end
    wr(2'd3, 16'd2);

    // R4 parity error, R7 clear, R13 error interrupt
    wr(2'd2, 16'h0804); loop = 1'b0;
    send_char(9'h001, 8, 1'b1, 1'b0, 1'b1);
    chk("R13 irq on error", irq, 1);
    rd(2'd1, r); chk("R4 parity flag", r, 16'h000F);
    rd(2'd1, r); chk("R7 cleared by read", r, 16'h0007);
    chk("R13 irq after clear", irq, 0);
    rd(2'd0, r); chk("R4 data kept", r, 16'h0001);

    // R5 framing error
    wr(2'd2, 16'h0000);
    send_char(9'h05A, 8, 1'b0, 1'b0, 1'b0);
    rd(2'd1, r); chk("R5 framing flag", r, 16'h0017);
    rd(2'd0, r); chk("R5 data", r, 16'h005A);

    // R6 overrun
    send_char(9'h011, 8, 1'b0, 1'b0, 1'b1);
    send_char(9'h022, 8, 1'b0, 1'b0, 1'b1);
    rd(2'd1, r); chk("R6 overrun flag", r, 16'h0027);
    rd(2'd0, r); chk("R6 first kept", r, 16'h0011);
    rd(2'd1, r); chk("R7 overrun cleared", r, 16'h0006);

    // R8 short glitch
    rx_drv = 1'b0; repeat (8) @(negedge clk); rx_drv = 1'b1;
    repeat (96) @(negedge clk);
    rd(2'd1, r); chk("R8 glitch ignored", r, 16'h0006);

    // R11 receive enable input
    wr(2'd2, 16'h0040); enrx_n = 1'b1;
    send_char(9'h033, 8, 1'b0, 1'b0, 1'b1);
    rd(2'd1, r); chk("R11 blocked", r, 16'h0006);
    enrx_n = 1'b0;
    send_char(9'h033, 8, 1'b0, 1'b0, 1'b1);
    rd(2'd0, r); chk("R11 allowed", r, 16'h0033);

    // R13/R14 interrupt and DMA requests
    wr(2'd2, 16'h3200); #1;
    chk("R14 R13 idle", {drq_tx, drq_rx, irq}, 3'b100);
    send_char(9'h044, 8, 1'b0, 1'b0, 1'b1);
    chk("R14 R13 rx full", {drq_tx, drq_rx, irq}, 3'b111);
    rd(2'd0, r); #1;
    chk("R14 after read", {drq_rx, irq}, 2'b00);
    wr(2'd2, 16'h0400); #1;
    chk("R13 tx empty irq", irq, 1);

    // R10 clear-to-send gating, R12 flow outputs
    wr(2'd2, 16'h01A0); cts_n = 1'b1; #1;
    chk("R12 idle outputs", {rts_n, rtr_n}, 2'b10);
    wr(2'd0, 16'h0066);
    repeat (96) @(negedge clk);
    chk("R10 line held", txd, 1);
    rd(2'd1, r); chk("R10 still waiting", r, 16'h0000);
    chk("R12 rts pending", rts_n, 0);
    loop = 1'b1;
    fork
      check_tx(16'h01A0, 16'h0066, 16'd2, "R10 released frame");
      begin @(negedge clk); cts_n = 1'b0; end
    join
    repeat (64) @(negedge clk);
    chk("R12 rtr full", {rts_n, rtr_n}, 2'b11);
    rd(2'd0, r); chk("R10 data", r, 16'h0066); #1;
    chk("R12 rtr free", rtr_n, 0);

    // R9 double buffering
    wr(2'd2, 16'h0000); loop = 1'b0;
    wr(2'd0, 16'h000F);
    fork
      begin
        check_tx(16'h0000, 16'h000F, 16'd2, "R9 first frame");
        check_tx(16'h0000, 16'h00F0, 16'd2, "R9 second frame");
      end
      begin
        logic [15:0] s;
        repeat (3) @(negedge clk);
        rd(2'd1, s); chk("R9 holding freed", s, 16'h0002);
        wr(2'd0, 16'h00F0);
        rd(2'd1, s); chk("R9 both busy", s, 16'h0000);
      end
    join
    repeat (64) @(negedge clk);
    rd(2'd1, r); chk("R9 idle again", r, 16'h0006);

    finish_run();
  end
endmodule